// File: doc/BRIEF.md
# Descriptor Chain Walker

This block drives one direction of a scatter-gather DMA channel. Software leaves a linked list of descriptors in memory, points the current-pointer register at the first one and writes the tail-pointer register. The walker then reads each descriptor one word at a time over a request/response port that allows one access in flight. It hands the buffer address, the length and the frame-boundary flags to a data mover. When the mover accepts them, the walker writes a completion status back into the descriptor and follows the next pointer.

The walk ends in one of two ways. If the descriptor just finished was the tail, the walker sets idle. If a fetched descriptor is already marked complete, it sets halted and touches nothing. A single-cycle pulse marks every descriptor that closes a frame. Run/stop and a self-clearing reset bit control the channel. Moving the payload bytes and raising interrupts belong to other blocks.

Descriptor byte offsets, all little-endian:

- 0x00: next pointer, low word.
- 0x04: next pointer, high word.
- 0x08: buffer address, low word.
- 0x0C: buffer address, high word.
- 0x18: control word.
- 0x1C: status word.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset the channel is halted, not idle, not running, with no reset flag, current pointer 0, and no memory request raised.
- R2: Each descriptor is fetched with one read per word, at byte offsets from the current pointer in this order: 0x00, 0x04 (only when ADDR_W > 32), 0x08, 0x0C (only when ADDR_W > 32), 0x18, 0x1C. Pointers are little-endian, with the high word at +4.
- R3: The control word carries the length in bits 22:0, end-of-frame in bit 26 and start-of-frame in bit 27. These fields, with the buffer address, are presented on the transfer port, held stable until accepted, and all other control bits are ignored.
- R4: A fetched descriptor whose status bit 31 is already set makes the walker set halted. It then issues no transfer and no write, and leaves the current pointer unchanged.
- R5: After the transfer is accepted, the walker writes the status word at offset 0x1C as {1'b1, 8'h00, length[22:0]}.
- R6: After each descriptor the current pointer takes that descriptor's next pointer. If the finished descriptor was at the tail pointer, idle is set and the walk stops.
- R7: A tail-pointer write clears idle and starts a walk only when run/stop is set. With run/stop clear, or after run/stop is set later on its own, no memory request is made.
- R8: A control write with run/stop set, outside reset, clears halted and idle on the next cycle.
- R9: A control write with the reset bit sets the reset flag and puts run/stop, halted, idle and both pointers at their reset values. Further control writes are ignored while the flag is set. The next control read clears the flag.
- R10: pkt_done pulses for one cycle, the cycle after a transfer with end-of-frame set is accepted, and never for other descriptors.
- R11: Only one memory request is outstanding: no request is raised while a response is pending, and address, write flag and data hold steady until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_run | input | 1 | Run/stop value written |
| ctl_reset | input | 1 | Reset bit value written |
| ctl_rd | input | 1 | Control register read strobe (clears reset flag) |
| cur_wr | input | 1 | Current-pointer write strobe |
| tail_wr | input | 1 | Tail-pointer write strobe |
| ptr_wdata | input | ADDR_W | Pointer write data |
| cur_ptr | output | ADDR_W | Current descriptor pointer |
| run_q | output | 1 | Run/stop state |
| rst_flag | output | 1 | Reset bit as read back |
| halted | output | 1 | Halted status flag |
| idle | output | 1 | Idle status flag |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response (read data or write acknowledge) |
| mem_rsp_rdata | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer command valid |
| xfer_ready | input | 1 | Data mover accepts the command |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_len | output | LEN_W | Transfer length in bytes |
| xfer_sof | output | 1 | Start of frame |
| xfer_eof | output | 1 | End of frame |
| pkt_done | output | 1 | Frame-complete pulse |

## Verification
The bench builds the walker with ADDR_W = 40 and LEN_W = 23. This selects the wide fetch variant with six reads per descriptor. It also lets nonzero buffer high words show up in bits 39:32 of xfer_addr, which exercises the little-endian pointer assembly. The full 23-bit length field makes the all-ones maximum length and stray high control bits observable on xfer_len and in the written-back status. The memory and data-mover models stall on irregular patterns, so every handshake sees both immediate and delayed acceptance.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
   localparam int WORD_W      = 32;
   localparam int LEN_FIELD_W = 23;
   localparam int CTL_EOF_BIT = 26;
   localparam int CTL_SOF_BIT = 27;
   localparam int STS_DONE_BIT = 31;
   localparam logic [4:0] OFF_STATUS = 5'h1C;

   typedef enum logic [2:0] {
      W_WAIT, W_RDREQ, W_RDRSP, W_CHECK, W_XFER, W_WBREQ, W_WBRSP, W_NEXT
   } walk_st_t;

   // byte offset of fetch step idx; wide variant also reads upper pointer words
   function automatic logic [4:0] fetch_off(input logic wide, input logic [2:0] idx);
      logic [4:0] r;
      if (wide) begin
         case (idx)
            3'd0: r = 5'h00;
            3'd1: r = 5'h04;
            3'd2: r = 5'h08;
            3'd3: r = 5'h0C;
            3'd4: r = 5'h18;
            default: r = 5'h1C;
         endcase
      end else begin
         case (idx)
            3'd0: r = 5'h00;
            3'd1: r = 5'h08;
            3'd2: r = 5'h18;
            default: r = 5'h1C;
         endcase
      end
      return r;
   endfunction
endpackage

// File: rtl/sgw_chan_regs.sv
module sgw_chan_regs #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_run,
   input  logic              ctl_reset,
   input  logic              ctl_rd,
   input  logic              cur_wr,
   input  logic              tail_wr,
   input  logic [ADDR_W-1:0] ptr_wdata,
   input  logic              ev_adv,
   input  logic              ev_idle,
   input  logic              ev_halt,
   input  logic [ADDR_W-1:0] nxt_ptr,
   output logic              run_q,
   output logic              rst_flag,
   output logic              halted,
   output logic              idle,
   output logic              go,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic [ADDR_W-1:0] tail_ptr
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         rst_flag <= 1'b0;
         halted   <= 1'b1;
         idle     <= 1'b0;
         armed    <= 1'b0;
         cur_ptr  <= '0;
         tail_ptr <= '0;
      end else if (rst_flag || (ctl_wr && ctl_reset)) begin
         run_q    <= 1'b0;
         halted   <= 1'b1;
         idle     <= 1'b0;
         armed    <= 1'b0;
         cur_ptr  <= '0;
         tail_ptr <= '0;
         if (!rst_flag)   rst_flag <= 1'b1;
         else if (ctl_rd) rst_flag <= 1'b0;
      end else begin
         if (ctl_wr) begin
            run_q <= ctl_run;
            if (ctl_run) begin
               halted <= 1'b0;
               idle   <= 1'b0;
            end
         end
         if (tail_wr) begin
            tail_ptr <= ptr_wdata;
            idle     <= 1'b0;
            if (run_q) armed <= 1'b1;
         end
         if (cur_wr) cur_ptr <= ptr_wdata;
         if (ev_adv) cur_ptr <= nxt_ptr;
         if (ev_idle) begin
            idle  <= 1'b1;
            armed <= 1'b0;
         end
         if (ev_halt) begin
            halted <= 1'b1;
            armed  <= 1'b0;
         end
      end
   end

   assign go = armed && run_q && !idle && !halted && !rst_flag;

   // R9
   rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_flag |-> (halted && !run_q && !idle && cur_ptr == '0));
   // R8
   run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_run && !ctl_reset && !rst_flag && !ev_halt && !ev_idle)
      |=> (!halted && !idle));
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
   import sgw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] cur_ptr,
   input  logic [ADDR_W-1:0] tail_ptr,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [WORD_W-1:0] mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [WORD_W-1:0] mem_rsp_rdata,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [LEN_W-1:0]  xfer_len,
   output logic              xfer_sof,
   output logic              xfer_eof,
   output logic              pkt_done,
   output logic              ev_adv,
   output logic              ev_idle,
   output logic              ev_halt,
   output logic [ADDR_W-1:0] nxt_ptr
);
   localparam bit WIDE  = (ADDR_W > WORD_W);
   localparam int NW    = WIDE ? 6 : 4;
   localparam int IDX_W = 3;

   walk_st_t          st;
   logic [IDX_W-1:0]  fidx;
   logic [ADDR_W-1:0] base;
   logic [WORD_W-1:0] fw [NW];
   logic [WORD_W-1:0] d_ctl, d_sts;
   logic [ADDR_W-1:0] d_buf;

   generate
      if (WIDE) begin : g_wide
         logic [2*WORD_W-1:0] n64, b64;
         assign n64     = {fw[1], fw[0]};
         assign b64     = {fw[3], fw[2]};
         assign nxt_ptr = n64[ADDR_W-1:0];
         assign d_buf   = b64[ADDR_W-1:0];
         assign d_ctl   = fw[4];
         assign d_sts   = fw[5];
      end else begin : g_narrow
         assign nxt_ptr = fw[0][ADDR_W-1:0];
         assign d_buf   = fw[1][ADDR_W-1:0];
         assign d_ctl   = fw[2];
         assign d_sts   = fw[3];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= W_WAIT;
         fidx     <= '0;
         base     <= '0;
         pkt_done <= 1'b0;
         for (int i = 0; i < NW; i++) fw[i] <= '0;
      end else begin
         pkt_done <= 1'b0;
         case (st)
            W_WAIT: if (go) begin
               base <= cur_ptr;
               fidx <= '0;
               st   <= W_RDREQ;
            end
            W_RDREQ: if (mem_req_ready) st <= W_RDRSP;
            W_RDRSP: if (mem_rsp_valid) begin
               fw[fidx] <= mem_rsp_rdata;
               if (fidx == IDX_W'(NW - 1)) st <= W_CHECK;
               else begin
                  fidx <= fidx + 1'b1;
                  st   <= W_RDREQ;
               end
            end
            W_CHECK: st <= d_sts[STS_DONE_BIT] ? W_WAIT : W_XFER;
            W_XFER: if (xfer_ready) begin
               pkt_done <= d_ctl[CTL_EOF_BIT];
               st       <= W_WBREQ;
            end
            W_WBREQ: if (mem_req_ready) st <= W_WBRSP;
            W_WBRSP: if (mem_rsp_valid) st <= W_NEXT;
            default: st <= W_WAIT;
         endcase
      end
   end

   always_comb begin
      mem_req_valid = (st == W_RDREQ) || (st == W_WBREQ);
      mem_req_write = (st == W_WBREQ);
      mem_req_addr  = base + ADDR_W'((st == W_WBREQ) ? OFF_STATUS : fetch_off(WIDE, fidx));
      mem_req_wdata = {1'b1, {(WORD_W - 1 - LEN_FIELD_W){1'b0}}, d_ctl[LEN_FIELD_W-1:0]};
   end

   assign xfer_valid = (st == W_XFER);
   assign xfer_addr  = d_buf;
   assign xfer_len   = d_ctl[LEN_W-1:0];
   assign xfer_sof   = d_ctl[CTL_SOF_BIT];
   assign xfer_eof   = d_ctl[CTL_EOF_BIT];
   assign ev_halt    = (st == W_CHECK) && d_sts[STS_DONE_BIT];
   assign ev_adv     = (st == W_NEXT);
   assign ev_idle    = ev_adv && (base == tail_ptr);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
   // R11
   one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> !mem_req_valid);
   // R3
   xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len)));
   // R10
   pkt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> $past(xfer_valid && xfer_ready && xfer_eof));
   // R5
   wb_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> mem_req_wdata[STS_DONE_BIT]);
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_run,
   input  logic              ctl_reset,
   input  logic              ctl_rd,
   input  logic              cur_wr,
   input  logic              tail_wr,
   input  logic [ADDR_W-1:0] ptr_wdata,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic              run_q,
   output logic              rst_flag,
   output logic              halted,
   output logic              idle,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [31:0]       mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_rdata,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [LEN_W-1:0]  xfer_len,
   output logic              xfer_sof,
   output logic              xfer_eof,
   output logic              pkt_done
);
   generate
      if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr_w
         $error("sg_chain_walker: ADDR_W must lie in 8..64");
      end
      if (LEN_W < 1 || LEN_W > sgw_pkg::LEN_FIELD_W) begin : g_bad_len_w
         $error("sg_chain_walker: LEN_W must lie in 1..23");
      end
   endgenerate

   logic              go, ev_adv, ev_idle, ev_halt;
   logic [ADDR_W-1:0] tail_ptr, nxt_ptr;

   sgw_chan_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_run(ctl_run), .ctl_reset(ctl_reset), .ctl_rd(ctl_rd),
      .cur_wr(cur_wr), .tail_wr(tail_wr), .ptr_wdata(ptr_wdata),
      .ev_adv(ev_adv), .ev_idle(ev_idle), .ev_halt(ev_halt), .nxt_ptr(nxt_ptr),
      .run_q(run_q), .rst_flag(rst_flag), .halted(halted), .idle(idle), .go(go),
      .cur_ptr(cur_ptr), .tail_ptr(tail_ptr)
   );

   sgw_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .go(go), .cur_ptr(cur_ptr), .tail_ptr(tail_ptr),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_rdata(mem_rsp_rdata),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
      .xfer_len(xfer_len), .xfer_sof(xfer_sof), .xfer_eof(xfer_eof),
      .pkt_done(pkt_done),
      .ev_adv(ev_adv), .ev_idle(ev_idle), .ev_halt(ev_halt), .nxt_ptr(nxt_ptr)
   );
endmodule

// File: tb/sim_sg_chain_walker.sv
module sim_sg_chain_walker;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 40;
   localparam int LW = 23;
   localparam int ND = 4;
   // {buffer low word, buffer high word, control word}
   localparam logic [95:0] TBL [ND] = '{
      {32'h1000_0000, 32'h0000_005A, 32'h0800_0040},
      {32'h2000_0010, 32'h0000_0000, 32'h047F_FFFF},
      {32'h3000_0020, 32'h0000_0001, 32'h0C00_0000},
      {32'hDEAD_BEE0, 32'h0000_007F, 32'h8900_0123}
   };
   localparam logic [7:0] RD_OFFS [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C};

   logic clk = 1'b0, rst_n = 1'b0;
   logic ctl_wr = 0, ctl_run = 0, ctl_reset = 0, ctl_rd = 0, cur_wr = 0, tail_wr = 0;
   logic [AW-1:0] ptr_wdata = '0;
   logic [AW-1:0] cur_ptr, mem_req_addr, xfer_addr;
   logic run_q, rst_flag, halted, idle;
   logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
   logic [31:0] mem_req_wdata, mem_rsp_rdata;
   logic xfer_valid, xfer_ready, xfer_sof, xfer_eof, pkt_done;
   logic [LW-1:0] xfer_len;

   int checks = 0, fails = 0;
   logic [31:0] mem [64];
   logic [7:0]  tick = '0;
   logic        rsp_v = 1'b0;
   logic [31:0] rsp_d = '0;
   int rd_total = 0, xcnt = 0, pkts = 0, viol = 0;
   logic [7:0]    rdlog [8];
   logic [AW-1:0] xa [16];
   logic [LW-1:0] xl [16];
   logic          xs [16], xe [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_req_ready = tick[0] ^ tick[2];
   assign xfer_ready    = tick[1] | tick[3];
   assign mem_rsp_valid = rsp_v;
   assign mem_rsp_rdata = rsp_d;

   sg_chain_walker #(.ADDR_W(AW), .LEN_W(LW)) u0 (.*);

   always @(posedge clk) begin
      tick  <= tick + 1'b1;
      rsp_v <= 1'b0;
      if (rsp_v && mem_req_valid) viol <= viol + 1;
      if (mem_req_valid && mem_req_ready) begin
         rsp_v <= 1'b1;
         if (mem_req_write) mem[mem_req_addr[7:2]] <= mem_req_wdata;
         else begin
            rsp_d <= mem[mem_req_addr[7:2]];
            if (rd_total < 8) rdlog[rd_total] <= mem_req_addr[7:0];
            rd_total <= rd_total + 1;
         end
      end
      if (xfer_valid && xfer_ready && xcnt < 16) begin
         xa[xcnt] <= xfer_addr; xl[xcnt] <= xfer_len;
         xs[xcnt] <= xfer_sof;  xe[xcnt] <= xfer_eof;
         xcnt <= xcnt + 1;
      end
      if (pkt_done) pkts <= pkts + 1;
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic ctl_write(input logic run, input logic rst);
      @(negedge clk); ctl_wr = 1; ctl_run = run; ctl_reset = rst;
      @(negedge clk); ctl_wr = 0; ctl_run = 0; ctl_reset = 0;
   endtask

   task automatic ctl_read();
      @(negedge clk); ctl_rd = 1;
      @(negedge clk); ctl_rd = 0;
   endtask

   task automatic ptr_write(input logic tail, input logic [AW-1:0] v);
      @(negedge clk); ptr_wdata = v; cur_wr = !tail; tail_wr = tail;
      @(negedge clk); cur_wr = 0; tail_wr = 0;
   endtask

   task automatic wait_stop();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (idle || halted) break;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] <= '0;
      for (int k = 0; k < ND; k++) begin
         mem[16*k + 0] <= (k == ND-1) ? 32'h200 : 32'(64 * (k + 1));
         mem[16*k + 2] <= TBL[k][95:64];
         mem[16*k + 3] <= TBL[k][63:32];
         mem[16*k + 4] <= 32'hFFFF_FFFF;
         mem[16*k + 6] <= TBL[k][31:0];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 halted", 64'(halted), 1);
      chk("R1 idle", 64'(idle), 0);
      chk("R1 run", 64'(run_q), 0);
      chk("R1 rst_flag", 64'(rst_flag), 0);
      chk("R1 cur", 64'(cur_ptr), 0);
      chk("R1 mem_req_valid", 64'(mem_req_valid), 0);

      // R8 run clears halted
      ctl_write(1'b1, 1'b0);
      chk("R8 halted after run", 64'(halted), 0);
      ptr_write(1'b0, '0);
      ptr_write(1'b1, 40'hC0);
      wait_stop();
      // R6 chain walked to tail
      chk("R6 idle at tail", 64'(idle), 1);
      chk("R6 cur after tail", 64'(cur_ptr), 64'h200);
      chk("R2 read count", 64'(rd_total), 24);
      for (int i = 0; i < 6; i++) chk("R2 fetch offset", 64'(rdlog[i]), 64'(RD_OFFS[i]));
      chk("R3 transfer count", 64'(xcnt), ND);
      for (int k = 0; k < ND; k++) begin
         chk("R3 addr", 64'(xa[k]), 64'({TBL[k][39:32], TBL[k][95:64]}));
         chk("R3 len", 64'(xl[k]), 64'(TBL[k][22:0]));
         chk("R3 sof", 64'(xs[k]), 64'(TBL[k][27]));
         chk("R3 eof", 64'(xe[k]), 64'(TBL[k][26]));
         chk("R5 status written", 64'(mem[16*k + 7]), 64'({9'h100, TBL[k][22:0]}));
      end
      chk("R10 pulses for eof only", 64'(pkts), 2);
      chk("R11 no request during response", 64'(viol), 0);

      // R4 already-complete descriptor halts
      ptr_write(1'b0, '0);
      ptr_write(1'b1, 40'hC0);
      wait_stop();
      chk("R4 halted", 64'(halted), 1);
      chk("R4 idle", 64'(idle), 0);
      chk("R4 cur unchanged", 64'(cur_ptr), 0);
      chk("R4 no transfer", 64'(xcnt), ND);
      chk("R4 reads only", 64'(rd_total), 30);

      ctl_write(1'b1, 1'b0);
      chk("R8 halted cleared", 64'(halted), 0);
      chk("R8 idle clear", 64'(idle), 0);

      // R7 tail write while stopped does nothing
      ctl_write(1'b0, 1'b0);
      @(negedge clk); mem[7] <= '0;
      ptr_write(1'b1, '0);
      repeat (40) @(negedge clk);
      chk("R7 no reads when stopped", 64'(rd_total), 30);
      ctl_write(1'b1, 1'b0);
      repeat (40) @(negedge clk);
      chk("R7 run alone does not start", 64'(rd_total), 30);
      ptr_write(1'b1, '0);
      wait_stop();
      chk("R7 walk after tail write", 64'(xcnt), ND + 1);
      chk("R6 single descriptor tail", 64'(cur_ptr), 64'h40);
      chk("R6 idle single", 64'(idle), 1);
      chk("R5 rewritten status", 64'(mem[7]), 64'h8000_0040);
      chk("R10 no pulse without eof", 64'(pkts), 2);

      // R9 reset bit
      ctl_write(1'b1, 1'b1);
      chk("R9 flag set", 64'(rst_flag), 1);
      chk("R9 halted", 64'(halted), 1);
      chk("R9 idle", 64'(idle), 0);
      chk("R9 cur", 64'(cur_ptr), 0);
      ctl_write(1'b1, 1'b0);
      chk("R9 write ignored", 64'(run_q), 0);
      ctl_read();
      chk("R9 flag cleared by read", 64'(rst_flag), 0);
      ctl_write(1'b1, 1'b0);
      chk("R9 run after clear", 64'(run_q), 1);
      chk("R8 halted after clear", 64'(halted), 0);
      chk("R11 final", 64'(viol), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule